// File: doc/BRIEF.md
# Random Number Generator Register Front End

This block sits between a simple register bus and a random number generator core. Software reads a block of four 32-bit random words. A sticky status register shows when those words are fresh, and it latches the alarm pulses from a health monitor. A control register turns the generator on and picks which alarms may raise the single interrupt line. A configuration register holds the refill timing limits, which the block passes straight to the core. Two read-only words report the build options and the revision.

The refill handshake works through the ready bit of the status register. While ready is clear and the generator is enabled, the block holds a refill request towards the core. The core answers with a one-cycle done pulse and a 128-bit value. The block captures that value into the four output words and sets ready, which drops the request. Software reads the words and then writes 1 to the ready bit. That clears ready and asks for the next block. Writes to the status register clear every bit written as 1, and alarm pulses set bits. An alarm pulse wins over a clear of the same bit in the same cycle.

Reads are combinational from the address. Writes take effect at the clock edge on which select and write are both high.

Top module: `rng_csr`

## Requirements
- R1: After reset, the status, control and configuration registers and all four output words read as zero, and both `irq` and `refillReq` are low.
- R2: The control register at offset 0x14 keeps only bit 10 and bits 7:1, and reads 0 in every other bit. The config register at 0x18 keeps bits 31:16 and 7:0. Offset 0x78 returns the OPTIONS parameter. Offset 0x7C returns the major revision in bits 27:24, the minor revision in 23:20 and the patch level in 19:16, with all other bits 0. Every offset not listed in these requirements reads as zero.
- R3: A write to the status register at 0x10 clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: A done pulse that arrives while the request is high does two things. It loads output word k (at offset 4*k, k = 0..3) from `refillData` bits 32k+31:32k. It also sets status bit 0 (ready).
- R5: `refillReq` is high exactly when control bit 10 is 1 and ready is 0. A done pulse that arrives while `refillReq` is low changes nothing. The output words hold their value while ready is set.
- R6: Pulse `failPulse[i]` sets status bit i+1. The status bits, from bit 1 up, are: shutdown overflow, stuck output, noise, run, long run, poker, monobit. Set bits stay set until cleared. A pulse wins over a clear of the same bit in the same cycle.
- R7: `irq` is the OR, over bits 1 to 7, of each status bit ANDed with the control bit at the same position. The ready bit never raises `irq`.
- R8: Writes to the output words, the options word and the revision word have no effect.
- R9: `genEnable` follows control bit 10. `maxRefill` follows config bits 31:16 and `minRefill` follows config bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Register access select |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| refillReq | output | 1 | Asks the core for a new block of words |
| refillDone | input | 1 | One-cycle pulse from the core when the block is ready |
| refillData | input | 128 | The new block, word 0 in the low bits |
| failPulse | input | 7 | Health alarm pulses for status bits 7:1 |
| irq | output | 1 | Interrupt for unmasked alarms |
| genEnable | output | 1 | Generator enable to the core |
| maxRefill | output | 16 | Maximum refill cycle count |
| minRefill | output | 8 | Minimum refill cycle count |

## Verification
Two properties assume an orderly core. The ready-edge property assumes that ready rises only through a done pulse that was accepted. The word-stability property relies on the core never capturing data while the request is low. The bench models the core to fit: it drives `refillDone` as a single-cycle pulse, and it changes inputs only on the falling edge. Two things break the handshake on purpose: a done pulse sent while ready is set, and an alarm pulse that collides with a clear. Both cases are still legal inputs that the block must tolerate.

// File: rtl/rngcsr_pkg.sv
package rngcsr_pkg;
  localparam int OFF_STATUS  = 'h10;
  localparam int OFF_CONTROL = 'h14;
  localparam int OFF_CONFIG  = 'h18;
  localparam int OFF_OPTIONS = 'h78;
  localparam int OFF_REV     = 'h7C;
  localparam int EN_BIT      = 10;
  localparam int MAXCNT_LSB  = 16;
  localparam int REV_MAJ_LSB = 24;
  localparam int REV_MIN_LSB = 20;
  localparam int REV_PAT_LSB = 16;

  typedef struct packed {
    logic wrCtrl;
    logic wrCfg;
    logic capture;
  } strobe_t;
endpackage

// File: rtl/rngcsr_ctrl.sv
module rngcsr_ctrl
  import rngcsr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 32,
  parameter int FAIL_N = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWdata,
  input  logic              refillDone,
  input  logic [FAIL_N-1:0] failPulse,
  input  logic              genEn,
  input  logic [FAIL_N-1:0] intEn,
  output strobe_t           strb,
  output logic [FAIL_N:0]   status,
  output logic              refillReq,
  output logic              irq
);
  localparam int ST_W = FAIL_N + 1;

  logic            wrHit, wrStat;
  logic [ST_W-1:0] clrMask, setMask, statusNext;
  logic            unusedBits;

  assign wrHit  = busSel & busWr;
  assign wrStat = wrHit && (busAddr == ADDR_W'(OFF_STATUS));

  assign refillReq    = genEn & ~status[0];
  assign strb.capture = refillDone & refillReq;
  assign strb.wrCtrl  = wrHit && (busAddr == ADDR_W'(OFF_CONTROL));
  assign strb.wrCfg   = wrHit && (busAddr == ADDR_W'(OFF_CONFIG));

  assign clrMask    = wrStat ? busWdata[ST_W-1:0] : '0;
  assign setMask    = {failPulse, strb.capture};
  assign statusNext = (status & ~clrMask) | setMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) status <= '0;
    else       status <= statusNext;
  end

  assign irq = |(status[FAIL_N:1] & intEn);

  assign unusedBits = ^busWdata;

  // R3: a written 1 on ready clears it unless a refill lands at once
  p_clear_ready_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && busWdata[0] && !refillDone) |=> !status[0]);

  // R4: ready only rises after an accepted done pulse
  p_ready_source_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[0]) |-> $past(refillDone && refillReq));

  // R6: pulsed alarm bits are set on the next edge
  p_pulse_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
    (|failPulse) |=> (($past(failPulse) & ~status[FAIL_N:1]) == '0));

  // R6: alarm bits stay set unless cleared
  p_fail_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((status[FAIL_N:1] & ~clrMask[FAIL_N:1]) != '0) |=>
      (($past(status[FAIL_N:1] & ~clrMask[FAIL_N:1]) & ~status[FAIL_N:1]) == '0));
endmodule

// File: rtl/rngcsr_data.sv
module rngcsr_data
  import rngcsr_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter int              WORD_W    = 32,
  parameter int              NUM_WORDS = 4,
  parameter int              FAIL_N    = 7,
  parameter int              MAX_W     = 16,
  parameter int              MIN_W     = 8,
  parameter logic [3:0]      REV_MAJ   = 4'd2,
  parameter logic [3:0]      REV_MIN   = 4'd3,
  parameter logic [3:0]      REV_PAT   = 4'd5,
  parameter logic [WORD_W-1:0] OPTIONS = 'h0104
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     strb,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic [WORD_W-1:0]           busWdata,
  input  logic [NUM_WORDS*WORD_W-1:0] refillData,
  input  logic [FAIL_N:0]             status,
  output logic [WORD_W-1:0]           busRdata,
  output logic                        genEn,
  output logic [FAIL_N-1:0]           intEn,
  output logic [MAX_W-1:0]            maxRefill,
  output logic [MIN_W-1:0]            minRefill
);
  logic [NUM_WORDS-1:0][WORD_W-1:0] words;
  logic [WORD_W-1:0] ctrlView, cfgView, revView;
  logic unusedBits;

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             words[k] <= '0;
      else if (strb.capture) words[k] <= refillData[k*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genEn <= 1'b0;
      intEn <= '0;
    end else if (strb.wrCtrl) begin
      genEn <= busWdata[EN_BIT];
      intEn <= busWdata[FAIL_N:1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maxRefill <= '0;
      minRefill <= '0;
    end else if (strb.wrCfg) begin
      maxRefill <= busWdata[MAXCNT_LSB +: MAX_W];
      minRefill <= busWdata[MIN_W-1:0];
    end
  end

  assign ctrlView = (WORD_W'(genEn) << EN_BIT) | (WORD_W'(intEn) << 1);
  assign cfgView  = (WORD_W'(maxRefill) << MAXCNT_LSB) | WORD_W'(minRefill);
  assign revView  = (WORD_W'(REV_MAJ) << REV_MAJ_LSB) |
                    (WORD_W'(REV_MIN) << REV_MIN_LSB) |
                    (WORD_W'(REV_PAT) << REV_PAT_LSB);

  always_comb begin
    busRdata = '0;
    for (int k = 0; k < NUM_WORDS; k++)
      if (busAddr == ADDR_W'(k * 4)) busRdata = words[k];
    case (busAddr)
      ADDR_W'(OFF_STATUS):  busRdata = WORD_W'(status);
      ADDR_W'(OFF_CONTROL): busRdata = ctrlView;
      ADDR_W'(OFF_CONFIG):  busRdata = cfgView;
      ADDR_W'(OFF_OPTIONS): busRdata = OPTIONS;
      ADDR_W'(OFF_REV):     busRdata = revView;
      default: ;
    endcase
  end

  assign unusedBits = ^busWdata;

  // R5: output words hold while ready stays set
  p_words_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (status[0] && $past(status[0])) |-> $stable(words));
endmodule

// File: rtl/rng_csr.sv
module rng_csr
  import rngcsr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 4,
  parameter int FAIL_N    = 7,
  parameter int MAX_W     = 16,
  parameter int MIN_W     = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        busSel,
  input  logic                        busWr,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic [WORD_W-1:0]           busWdata,
  output logic [WORD_W-1:0]           busRdata,
  output logic                        refillReq,
  input  logic                        refillDone,
  input  logic [NUM_WORDS*WORD_W-1:0] refillData,
  input  logic [FAIL_N-1:0]           failPulse,
  output logic                        irq,
  output logic                        genEnable,
  output logic [MAX_W-1:0]            maxRefill,
  output logic [MIN_W-1:0]            minRefill
);
  strobe_t           strb;
  logic [FAIL_N:0]   status;
  logic [FAIL_N-1:0] intEn;

  rngcsr_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .FAIL_N(FAIL_N)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .refillDone(refillDone),
    .failPulse(failPulse), .genEn(genEnable), .intEn(intEn),
    .strb(strb), .status(status), .refillReq(refillReq), .irq(irq)
  );

  rngcsr_data #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS),
                .FAIL_N(FAIL_N), .MAX_W(MAX_W), .MIN_W(MIN_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr),
    .busWdata(busWdata), .refillData(refillData), .status(status),
    .busRdata(busRdata), .genEn(genEnable), .intEn(intEn),
    .maxRefill(maxRefill), .minRefill(minRefill)
  );

  // R7: an interrupt needs at least one alarm bit set
  p_irq_needs_alarm_r7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (|status[FAIL_N:1]));
endmodule

// File: tb/sim_rng_csr.sv
`timescale 1ns/1ps
module sim_rng_csr;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busSel = 1'b0, busWr = 1'b0;
  logic [7:0]   busAddr = '0;
  logic [31:0]  busWdata = '0;
  logic [31:0]  busRdata;
  logic         refillReq, refillDone = 1'b0;
  logic [127:0] refillData = '0;
  logic [6:0]   failPulse = '0;
  logic         irq, genEnable;
  logic [15:0]  maxRefill;
  logic [7:0]   minRefill;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  rng_csr u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .refillReq(refillReq), .refillDone(refillDone), .refillData(refillData),
    .failPulse(failPulse), .irq(irq), .genEnable(genEnable),
    .maxRefill(maxRefill), .minRefill(minRefill)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    busAddr = a; busSel = 1'b1; busWr = 1'b0;
    #1;
    d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic coreDone(input logic [127:0] d);
    @(negedge clk);
    refillDone = 1'b1; refillData = d;
    @(negedge clk);
    refillDone = 1'b0;
    #1;
  endtask

  task automatic pulseFail(input logic [6:0] m);
    @(negedge clk);
    failPulse = m;
    @(negedge clk);
    failPulse = '0;
    #1;
  endtask

  task automatic checkWords(input string tag, input logic [127:0] exp);
    logic [31:0] v;
    for (int k = 0; k < 4; k++) begin
      busRead(8'(k * 4), v);
      check(tag, v, exp[k*32 +: 32]);
    end
  endtask

  task automatic testReset();
    logic [31:0] v;
    busRead(8'h10, v); check("R1 status", v, 32'h0);
    busRead(8'h14, v); check("R1 control", v, 32'h0);
    busRead(8'h18, v); check("R1 config", v, 32'h0);
    checkWords("R1 words", 128'h0);
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 refillReq", 32'(refillReq), 32'h0);
  endtask

  task automatic testRegMap();
    logic [31:0] v;
    busWrite(8'h14, 32'hFFFF_FFFF);
    busRead(8'h14, v); check("R2 control bits", v, 32'h0000_04FE);
    check("R9 genEnable", 32'(genEnable), 32'h1);
    busWrite(8'h14, 32'h0);
    check("R9 genEnable off", 32'(genEnable), 32'h0);
    busWrite(8'h18, 32'hFFFF_FFFF);
    busRead(8'h18, v); check("R2 config bits", v, 32'hFFFF_00FF);
    busWrite(8'h18, 32'h1234_5678);
    busRead(8'h18, v); check("R2 config value", v, 32'h1234_0078);
    check("R9 maxRefill", 32'(maxRefill), 32'h1234);
    check("R9 minRefill", 32'(minRefill), 32'h78);
    busRead(8'h7C, v); check("R2 revision", v, 32'h0235_0000);
    busRead(8'h78, v); check("R2 options", v, 32'h0000_0104);
    busRead(8'h40, v); check("R2 unmapped 0x40", v, 32'h0);
    busRead(8'h1C, v); check("R2 unmapped 0x1C", v, 32'h0);
  endtask

  task automatic testRefill();
    logic [31:0] v;
    logic [127:0] d1 = 128'hA3A3_0003_A2A2_0002_A1A1_0001_A0A0_0000;
    logic [127:0] d2 = 128'hDEAD_BEEF_DEAD_BEEF_DEAD_BEEF_DEAD_BEEF;
    logic [127:0] d3 = 128'h0F0F_3333_5555_7777_9999_BBBB_DDDD_FFFF;
    #1; check("R5 no req when disabled", 32'(refillReq), 32'h0);
    coreDone(d2);
    checkWords("R5 done ignored while disabled", 128'h0);
    busWrite(8'h14, 32'h0000_0400);
    #1; check("R5 req when enabled", 32'(refillReq), 32'h1);
    coreDone(d1);
    busRead(8'h10, v); check("R4 ready set", v, 32'h1);
    check("R5 req drops", 32'(refillReq), 32'h0);
    checkWords("R4 captured words", d1);
    coreDone(d2);
    checkWords("R5 words stable while ready", d1);
    busWrite(8'h00, 32'h1111_1111);
    busWrite(8'h0C, 32'h2222_2222);
    checkWords("R8 word writes ignored", d1);
    busWrite(8'h7C, 32'hFFFF_FFFF);
    busWrite(8'h78, 32'hFFFF_FFFF);
    busRead(8'h7C, v); check("R8 revision unchanged", v, 32'h0235_0000);
    busRead(8'h78, v); check("R8 options unchanged", v, 32'h0000_0104);
    busWrite(8'h10, 32'h0);
    busRead(8'h10, v); check("R3 zero write keeps", v, 32'h1);
    busWrite(8'h10, 32'h1);
    busRead(8'h10, v); check("R3 ready cleared", v, 32'h0);
    check("R5 req after clear", 32'(refillReq), 32'h1);
    checkWords("R5 words until refill", d1);
    coreDone(d3);
    checkWords("R4 second block", d3);
    busRead(8'h10, v); check("R4 ready again", v, 32'h1);
  endtask

  task automatic testFail();
    logic [31:0] v;
    pulseFail(7'h04);
    busRead(8'h10, v); check("R6 noise bit", v, 32'h09);
    check("R7 masked", 32'(irq), 32'h0);
    busWrite(8'h14, 32'h0000_0408);
    #1; check("R7 unmasked", 32'(irq), 32'h1);
    busWrite(8'h10, 32'h08);
    busRead(8'h10, v); check("R3 clear alarm", v, 32'h01);
    check("R7 irq drops", 32'(irq), 32'h0);
    pulseFail(7'h7F);
    busRead(8'h10, v); check("R6 all alarms", v, 32'hFF);
    check("R7 irq all", 32'(irq), 32'h1);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = 8'h10; busWdata = 32'hFE;
    failPulse = 7'h01;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; failPulse = '0;
    busRead(8'h10, v); check("R6 pulse beats clear", v, 32'h03);
    check("R7 bit1 masked", 32'(irq), 32'h0);
    busWrite(8'h14, 32'h0000_0401);
    busWrite(8'h10, 32'h02);
    busRead(8'h10, v); check("R3 ready kept", v, 32'h01);
    check("R7 ready no irq", 32'(irq), 32'h0);
    busRead(8'h14, v); check("R2 bit0 not kept", v, 32'h0000_0400);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    testReset();
    testRegMap();
    testRefill();
    testFail();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule